// File: doc/BRIEF.md
# Multi-Stream Associative Cell Array

This block is a row of simple associative processing cells shared among several instruction streams, with far fewer streams than cells. Each cell holds a small word store, the number of the stream it currently follows, an active flag, a responder flag, a sticky error flag and a short stack of saved active flags. On every clock the array receives one wide broadcast word. The word holds one instruction slot per stream, and each cell executes only the slot that belongs to its own stream. Slots for different streams therefore act on their own partitions of cells in the same cycle.

A stream can run an equality search of a stored word against a broadcast key, which marks responders. It can narrow its active set to responders or to non-responders while saving the previous set, restore that set, wake all of its cells, write a store word, and move its active cells to another stream. Moving cells to the stream that collects idle cells is a separate operation. Each cell has a two-state controller with the states CELL_LIVE (the cell executes data operations) and CELL_MASKED (the cell only follows mask operations). The transitions are as follows:
- LIVE to MASKED when a selection excludes the cell or when a restore pops a cleared flag.
- MASKED to LIVE when the stream wakes all of its cells or when a restore pops a set flag.
- Either state goes to LIVE when a switch or a retire moves the cell to a new stream.

Top module: `mstream_cell_array`

## Requirements
- R1: After reset every cell follows stream 0 and is active, and its responder and error flags are 0 with an empty stack. Store word 0 holds the cell's own index and the other words hold 0.
- R2: Slot s of `bcast_word` occupies bits [s*16 +: 16] and is laid out, from the top bit down, as opcode[3:0], target stream[1:0], address[1:0], key[7:0]. A cell executes only the slot of its own stream, and all slots act on the same clock edge.
- R3: SEARCH (opcode 2) sets each active cell's responder flag to whether store[address] equals the key. The result is visible after the edge that captures the slot.
- R4: An inactive cell leaves its state unchanged under SEARCH, LOAD, SWITCH and RETIRE.
- R5: LOAD (opcode 8) writes the key into store[address] of each active cell.
- R6: SELECT-RESPONDERS (opcode 3) and SELECT-NON-RESPONDERS (opcode 4) push every cell's active flag onto that cell's stack. The cell then stays active only if it was active and its responder flag is 1 (opcode 3) or 0 (opcode 4).
- R7: RESTORE (opcode 5) pops the stack into the active flag. On an empty stack the active flag is unchanged and a sticky error flag is set.
- R8: The stack holds 4 entries. A push onto a full stack discards the oldest entry.
- R9: ACTIVATE-ALL (opcode 1) makes every cell of the stream active whatever its mask state, and leaves the stack alone.
- R10: SWITCH (opcode 6) moves each active cell to the target stream, where it is active with a cleared responder flag and an empty stack. From the next cycle it executes the new stream's slot.
- R11: RETIRE (opcode 7) does the same as SWITCH, with the idle-managing stream (3 by default) as the target.
- R12: NOP (opcode 0) and the unassigned opcodes 9 to 15 change nothing.
- R13: `stream_any_resp[s]` is 1 exactly when some cell following stream s is both active and responding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcast_word | input | N_STREAMS*16 | One instruction slot per stream |
| cell_active | output | N_CELLS | Active flag of each cell |
| cell_resp | output | N_CELLS | Responder flag of each cell |
| cell_err | output | N_CELLS | Sticky empty-stack restore error of each cell |
| cell_sid | output | N_CELLS*2 | Stream followed by each cell, cell c at [2c +: 2] |
| stream_any_resp | output | N_STREAMS | Per-stream OR of active responders |

## Verification
The bench uses the default build: eight cells, four streams, a four-word store of eight-bit words, a four-deep stack and stream 3 as the idle stream. Because each cell holds a distinct index, a single search can isolate one cell. Because there are four streams, the idle stream differs from the two working streams, so three partitions run side by side in one broadcast. With a four-deep stack, five nested selections reach the discard-oldest case and a later restore hits the empty-stack error.

// File: rtl/mstream_pkg.sv
package mstream_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 4'd0,
        OP_ACT_ALL   = 4'd1,
        OP_SEARCH    = 4'd2,
        OP_SEL_RESP  = 4'd3,
        OP_SEL_NRESP = 4'd4,
        OP_RESTORE   = 4'd5,
        OP_SWITCH    = 4'd6,
        OP_RETIRE    = 4'd7,
        OP_LOAD      = 4'd8
    } op_e;

    typedef enum logic {
        CELL_MASKED = 1'b0,
        CELL_LIVE   = 1'b1
    } cell_st_e;

endpackage

// File: rtl/mstream_slot_pick.sv
module mstream_slot_pick
    import mstream_pkg::*;
#(
    parameter int N_STREAMS = 4,
    parameter int SID_W     = 2,
    parameter int ADDR_W    = 2,
    parameter int WORD_W    = 8,
    localparam int SLOT_W   = OP_W + SID_W + ADDR_W + WORD_W,
    localparam int N_SLOTS  = 1 << SID_W
) (
    input  logic [N_STREAMS*SLOT_W-1:0] bcast_word,
    input  logic [SID_W-1:0]            sid,
    output op_e                         op,
    output logic [SID_W-1:0]            tgt,
    output logic [ADDR_W-1:0]           addr,
    output logic [WORD_W-1:0]           key
);

    logic [SLOT_W-1:0] slots [N_SLOTS];
    logic [SLOT_W-1:0] sel;

    // Stream numbers with no slot read as NOP.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        if (s < N_STREAMS) begin : g_real
            assign slots[s] = bcast_word[s*SLOT_W +: SLOT_W];
        end else begin : g_pad
            assign slots[s] = '0;
        end
    end

    assign sel  = slots[sid];
    assign op   = op_e'(sel[SLOT_W-1 -: OP_W]);
    assign tgt  = sel[ADDR_W+WORD_W +: SID_W];
    assign addr = sel[WORD_W +: ADDR_W];
    assign key  = sel[WORD_W-1:0];

endmodule

// File: rtl/mstream_mask_stack.sv
module mstream_mask_stack #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic push,
    input  logic pop,
    input  logic din,
    output logic top_bit,
    output logic empty
);

    logic [DEPTH-1:0] stk;
    logic [CNT_W-1:0] cnt;

    // stk[0] is the newest entry; the oldest falls off the top end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk <= '0;
            cnt <= '0;
        end else if (clear) begin
            stk <= '0;
            cnt <= '0;
        end else if (push) begin
            stk <= {stk[DEPTH-2:0], din};
            if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
        end else if (pop && (cnt != '0)) begin
            stk <= {1'b0, stk[DEPTH-1:1]};
            cnt <= cnt - 1'b1;
        end
    end

    assign top_bit = stk[0];
    assign empty   = (cnt == '0);

endmodule

// File: rtl/mstream_cell.sv
module mstream_cell
    import mstream_pkg::*;
#(
    parameter int N_STREAMS   = 4,
    parameter int SID_W       = 2,
    parameter int ADDR_W      = 2,
    parameter int WORD_W      = 8,
    parameter int STORE_DEPTH = 4,
    parameter int STACK_DEPTH = 4,
    parameter int IDLE_SID    = 3,
    parameter int CELL_IDX    = 0,
    localparam int SLOT_W     = OP_W + SID_W + ADDR_W + WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_STREAMS*SLOT_W-1:0] bcast_word,
    output logic                        active,
    output logic                        resp,
    output logic                        err,
    output logic [SID_W-1:0]            sid
);

    op_e               op;
    logic [SID_W-1:0]  tgt;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] key;

    cell_st_e          st, st_n;
    logic              resp_q, resp_n;
    logic              err_q, err_n;
    logic [SID_W-1:0]  sid_q, sid_n;
    logic              push, pop, clr, wr_en;
    logic              stk_top, stk_empty;
    logic              live;
    logic [WORD_W-1:0] mem [STORE_DEPTH];

    mstream_slot_pick #(
        .N_STREAMS(N_STREAMS), .SID_W(SID_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
    ) u_pick (
        .bcast_word(bcast_word), .sid(sid_q),
        .op(op), .tgt(tgt), .addr(addr), .key(key)
    );

    mstream_mask_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .clear(clr), .push(push), .pop(pop),
        .din(live), .top_bit(stk_top), .empty(stk_empty)
    );

    assign live = (st == CELL_LIVE);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CELL_LIVE;
        else        st <= st_n;
    end

    // Next state and per-cell effects of the selected slot.
    always_comb begin
        st_n   = st;
        resp_n = resp_q;
        err_n  = err_q;
        sid_n  = sid_q;
        push   = 1'b0;
        pop    = 1'b0;
        clr    = 1'b0;
        wr_en  = 1'b0;
        unique case (op)
            OP_ACT_ALL: st_n = CELL_LIVE;
            OP_SEARCH: begin
                if (live) resp_n = (mem[addr] == key);
            end
            OP_SEL_RESP: begin
                push = 1'b1;
                if (live && !resp_q) st_n = CELL_MASKED;
            end
            OP_SEL_NRESP: begin
                push = 1'b1;
                if (live && resp_q) st_n = CELL_MASKED;
            end
            OP_RESTORE: begin
                if (stk_empty) begin
                    err_n = 1'b1;
                end else begin
                    pop  = 1'b1;
                    st_n = stk_top ? CELL_LIVE : CELL_MASKED;
                end
            end
            OP_SWITCH: begin
                if (live) begin
                    sid_n  = tgt;
                    resp_n = 1'b0;
                    clr    = 1'b1;
                    st_n   = CELL_LIVE;
                end
            end
            OP_RETIRE: begin
                if (live) begin
                    sid_n  = SID_W'(IDLE_SID);
                    resp_n = 1'b0;
                    clr    = 1'b1;
                    st_n   = CELL_LIVE;
                end
            end
            OP_LOAD: begin
                if (live) wr_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= 1'b0;
            err_q  <= 1'b0;
            sid_q  <= '0;
            for (int k = 0; k < STORE_DEPTH; k++)
                mem[k] <= (k == 0) ? WORD_W'(CELL_IDX) : '0;
        end else begin
            resp_q <= resp_n;
            err_q  <= err_n;
            sid_q  <= sid_n;
            if (wr_en) mem[addr] <= key;
        end
    end

    assign active = live;
    assign resp   = resp_q;
    assign err    = err_q;
    assign sid    = sid_q;

endmodule

// File: rtl/mstream_cell_array.sv
module mstream_cell_array
    import mstream_pkg::*;
#(
    parameter int N_CELLS     = 8,
    parameter int N_STREAMS   = 4,
    parameter int WORD_W      = 8,
    parameter int STORE_DEPTH = 4,
    parameter int STACK_DEPTH = 4,
    parameter int IDLE_SID    = N_STREAMS - 1,
    localparam int SID_W      = $clog2(N_STREAMS),
    localparam int ADDR_W     = $clog2(STORE_DEPTH),
    localparam int SLOT_W     = OP_W + SID_W + ADDR_W + WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_STREAMS*SLOT_W-1:0] bcast_word,
    output logic [N_CELLS-1:0]          cell_active,
    output logic [N_CELLS-1:0]          cell_resp,
    output logic [N_CELLS-1:0]          cell_err,
    output logic [N_CELLS*SID_W-1:0]    cell_sid,
    output logic [N_STREAMS-1:0]        stream_any_resp
);

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
        mstream_cell #(
            .N_STREAMS(N_STREAMS), .SID_W(SID_W), .ADDR_W(ADDR_W),
            .WORD_W(WORD_W), .STORE_DEPTH(STORE_DEPTH),
            .STACK_DEPTH(STACK_DEPTH), .IDLE_SID(IDLE_SID), .CELL_IDX(c)
        ) u_cell (
            .clk(clk), .rst_n(rst_n), .bcast_word(bcast_word),
            .active(cell_active[c]), .resp(cell_resp[c]),
            .err(cell_err[c]), .sid(cell_sid[c*SID_W +: SID_W])
        );
    end

    // Per-stream OR of active responders.
    always_comb begin
        stream_any_resp = '0;
        for (int s = 0; s < N_STREAMS; s++) begin
            for (int c = 0; c < N_CELLS; c++) begin
                if (cell_active[c] && cell_resp[c] &&
                    (cell_sid[c*SID_W +: SID_W] == SID_W'(s)))
                    stream_any_resp[s] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mstream_cell_array_chk.sv
module mstream_cell_array_chk
    import mstream_pkg::*;
#(
    parameter int N_CELLS     = 8,
    parameter int N_STREAMS   = 4,
    parameter int WORD_W      = 8,
    parameter int STORE_DEPTH = 4,
    parameter int IDLE_SID    = N_STREAMS - 1,
    localparam int SID_W      = $clog2(N_STREAMS),
    localparam int ADDR_W     = $clog2(STORE_DEPTH),
    localparam int SLOT_W     = OP_W + SID_W + ADDR_W + WORD_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_STREAMS*SLOT_W-1:0] bcast_word,
    input logic [N_CELLS-1:0]          cell_active,
    input logic [N_CELLS-1:0]          cell_resp,
    input logic [N_CELLS-1:0]          cell_err,
    input logic [N_CELLS*SID_W-1:0]    cell_sid,
    input logic [N_STREAMS-1:0]        stream_any_resp
);

    for (genvar c = 0; c < N_CELLS; c++) begin : g_c
        logic [SID_W-1:0] sid_i;
        logic [OP_W-1:0]  op_i;
        logic [SID_W-1:0] tgt_i;
        assign sid_i = cell_sid[c*SID_W +: SID_W];
        assign op_i  = bcast_word[sid_i*SLOT_W + (SLOT_W-OP_W) +: OP_W];
        assign tgt_i = bcast_word[sid_i*SLOT_W + ADDR_W + WORD_W +: SID_W];

        // R4
        inactive_search_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cell_active[c] && op_i == 4'd2) |=> (cell_resp[c] == $past(cell_resp[c])));

        // R9
        act_all_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 4'd1) |=> cell_active[c]);

        // R10
        switch_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_active[c] && op_i == 4'd6) |=>
            (sid_i == $past(tgt_i) && cell_active[c] && !cell_resp[c]));

        // R11
        retire_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_active[c] && op_i == 4'd7) |=> (sid_i == SID_W'(IDLE_SID)));

        // R7
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cell_err[c] |=> cell_err[c]);

        // R12
        nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 4'd0) |=> ($stable(cell_active[c]) && $stable(cell_resp[c]) &&
                                $stable(cell_err[c]) && $stable(sid_i)));
    end

    // R13
    any_resp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stream_any_resp) |-> (|(cell_active & cell_resp)));

endmodule

bind mstream_cell_array mstream_cell_array_chk #(
    .N_CELLS(N_CELLS), .N_STREAMS(N_STREAMS), .WORD_W(WORD_W),
    .STORE_DEPTH(STORE_DEPTH), .IDLE_SID(IDLE_SID)
) u_chk (.*);

// File: tb/mstream_cell_array_bench.sv
module mstream_cell_array_bench;

    localparam int BW = 64;

    localparam int O_NOP  = 0;
    localparam int O_ACT  = 1;
    localparam int O_SRCH = 2;
    localparam int O_SELR = 3;
    localparam int O_SELN = 4;
    localparam int O_REST = 5;
    localparam int O_SW   = 6;
    localparam int O_RET  = 7;
    localparam int O_LOAD = 8;

    function automatic logic [15:0] sl(input int op, input int tgt, input int ad, input int k);
        return {4'(op), 2'(tgt), 2'(ad), 8'(k)};
    endfunction

    typedef struct packed {
        logic [7:0]    req;
        logic [BW-1:0] bw;
        logic [7:0]    act;
        logic [7:0]    resp;
        logic [7:0]    err;
        logic [15:0]   sid;
        logic [3:0]    any;
    } vec_t;

    localparam int NV = 15;
    // Slots written stream 3 first, stream 0 last.
    localparam vec_t TBL [NV] = '{
        // R3: find cell 3 by its index word
        '{8'd3,  {16'h0, 16'h0, 16'h0, sl(O_SRCH,0,0,3)},    8'hFF, 8'h08, 8'h00, 16'h0000, 4'h1},
        // R6: keep non-responders
        '{8'd6,  {16'h0, 16'h0, 16'h0, sl(O_SELN,0,0,0)},    8'hF7, 8'h08, 8'h00, 16'h0000, 4'h0},
        // R5: write word 1 in active cells
        '{8'd5,  {16'h0, 16'h0, 16'h0, sl(O_LOAD,0,1,8'h55)}, 8'hF7, 8'h08, 8'h00, 16'h0000, 4'h0},
        // R4: masked cell 3 keeps its responder flag
        '{8'd4,  {16'h0, 16'h0, 16'h0, sl(O_SRCH,0,1,8'h55)}, 8'hF7, 8'hFF, 8'h00, 16'h0000, 4'h1},
        // R7: restore saved mask
        '{8'd7,  {16'h0, 16'h0, 16'h0, sl(O_REST,0,0,0)},    8'hFF, 8'hFF, 8'h00, 16'h0000, 4'h1},
        // R5: cell 3 missed the write
        '{8'd5,  {16'h0, 16'h0, 16'h0, sl(O_SRCH,0,1,8'h55)}, 8'hFF, 8'hF7, 8'h00, 16'h0000, 4'h1},
        // R3: find cell 6
        '{8'd3,  {16'h0, 16'h0, 16'h0, sl(O_SRCH,0,0,6)},    8'hFF, 8'h40, 8'h00, 16'h0000, 4'h1},
        // R6: keep responders
        '{8'd6,  {16'h0, 16'h0, 16'h0, sl(O_SELR,0,0,0)},    8'h40, 8'h40, 8'h00, 16'h0000, 4'h1},
        // R10: cell 6 moves to stream 1
        '{8'd10, {16'h0, 16'h0, 16'h0, sl(O_SW,1,0,0)},      8'h40, 8'h00, 8'h00, 16'h1000, 4'h0},
        // R2: two streams act at once, cell 6 now decodes slot 1
        '{8'd2,  {16'h0, 16'h0, sl(O_SRCH,0,0,6), sl(O_REST,0,0,0)}, 8'hFF, 8'h40, 8'h00, 16'h1000, 4'h2},
        // R7: restore on empty stack sets error on stream 0 cells only
        '{8'd7,  {16'h0, 16'h0, 16'h0, sl(O_REST,0,0,0)},    8'hFF, 8'h40, 8'hBF, 16'h1000, 4'h2},
        // R11: retire stream 0 cells to idle stream 3
        '{8'd11, {16'h0, 16'h0, 16'h0, sl(O_RET,0,0,0)},     8'hFF, 8'h40, 8'hBF, 16'hDFFF, 4'h2},
        // R13: stream 0 has no cells, stream 3 finds cell 2
        '{8'd13, {sl(O_SRCH,0,0,2), 16'h0, 16'h0, sl(O_SRCH,0,0,6)}, 8'hFF, 8'h44, 8'hBF, 16'hDFFF, 4'hA},
        // R6: selections in streams 1 and 3 together
        '{8'd6,  {sl(O_SELR,0,0,0), 16'h0, sl(O_SELN,0,0,0), 16'h0}, 8'h04, 8'h44, 8'hBF, 16'hDFFF, 4'h8},
        // R9: stream 3 wakes its cells, cell 6 stays masked
        '{8'd9,  {sl(O_ACT,0,0,0), 16'h0, 16'h0, 16'h0},     8'hBF, 8'h44, 8'hBF, 16'hDFFF, 4'h8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] bw = '0;
    logic [7:0]    cell_active, cell_resp, cell_err;
    logic [15:0]   cell_sid;
    logic [3:0]    stream_any_resp;
    int            total = 0;
    int            fails = 0;

    always #4 clk = ~clk;

    mstream_cell_array #(
        .N_CELLS(8), .N_STREAMS(4), .WORD_W(8), .STORE_DEPTH(4), .STACK_DEPTH(4), .IDLE_SID(3)
    ) u_mstream_cell_array (
        .clk(clk), .rst_n(rst_n), .bcast_word(bw),
        .cell_active(cell_active), .cell_resp(cell_resp), .cell_err(cell_err),
        .cell_sid(cell_sid), .stream_any_resp(stream_any_resp)
    );

    task automatic chk(input int req, input string what, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive one broadcast for exactly one edge, then return to NOP.
    task automatic step(input logic [BW-1:0] w);
        @(negedge clk);
        bw = w;
        @(posedge clk);
        #1;
        bw = '0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic chk_reset_state();
        // R1: reset state
        chk(1, "reset active", cell_active, 8'hFF);
        chk(1, "reset resp", cell_resp, 8'h00);
        chk(1, "reset err", cell_err, 8'h00);
        chk(1, "reset sid", cell_sid, 16'h0000);
        chk(13, "reset any", stream_any_resp, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] a_keep, r_keep;
        do_reset();
        chk_reset_state();

        for (int v = 0; v < NV; v++) begin
            step(TBL[v].bw);
            chk(int'(TBL[v].req), "active", cell_active, TBL[v].act);
            chk(int'(TBL[v].req), "resp", cell_resp, TBL[v].resp);
            chk(int'(TBL[v].req), "err", cell_err, TBL[v].err);
            chk(int'(TBL[v].req), "sid", cell_sid, TBL[v].sid);
            chk(int'(TBL[v].req), "any", stream_any_resp, TBL[v].any);
        end

        do_reset();
        chk_reset_state();

        // R1: word 0 of cell 5 holds 5
        step({48'h0, sl(O_SRCH,0,0,5)});
        chk(1, "index word", cell_resp, 8'h20);

        // R8: five nested selections on a four-deep stack
        for (int i = 0; i < 5; i++) begin
            step({48'h0, sl(O_SRCH,0,0,i)});
            step({48'h0, sl(O_SELN,0,0,0)});
        end
        chk(8, "after 5 pushes", cell_active, 8'hE0);
        step({48'h0, sl(O_REST,0,0,0)});
        chk(8, "pop 1", cell_active, 8'hF0);
        step({48'h0, sl(O_REST,0,0,0)});
        chk(8, "pop 2", cell_active, 8'hF8);
        step({48'h0, sl(O_REST,0,0,0)});
        chk(8, "pop 3", cell_active, 8'hFC);
        step({48'h0, sl(O_REST,0,0,0)});
        chk(8, "pop 4", cell_active, 8'hFE);
        chk(7, "no error yet", cell_err, 8'h00);
        // R7: oldest entry was discarded, so the fifth pop finds the stack empty
        step({48'h0, sl(O_REST,0,0,0)});
        chk(7, "empty pop mask", cell_active, 8'hFE);
        chk(7, "empty pop err", cell_err, 8'hFF);

        // R12: unassigned opcode in every slot changes nothing
        a_keep = cell_active;
        r_keep = cell_resp;
        step({4{16'hF000 | 16'h0301}});
        chk(12, "unused op active", cell_active, a_keep);
        chk(12, "unused op resp", cell_resp, r_keep);
        chk(12, "unused op sid", cell_sid, 16'h0000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule